// File: doc/BRIEF.md
# Endian Address Adjuster

This block sits between a load/store unit and a 64-bit data bus whose byte lanes are numbered big-endian. It lets software switch little-endian operation on and off at run time without moving any data byte: in little-endian mode it flips the low address bits by a constant picked by the operand size. For each access it produces the adjusted address and the byte-lane enables, one cycle after the request.

The block keeps two endianness bits, one for user code and one for the supervisor, plus a flag that says which of the two is active. On an exception entry the supervisor bit governs the access issued in that same cycle. Page-table walk accesses always go out big-endian. A doubleword is never changed by the address flip, so a doubleword written in one mode reads back with the same byte order after a mode switch. An optional data stage reverses the eight bytes of all write and read data, so that devices on the board see true little-endian order.

Top module: `lsu_endian_adapt`

## Requirements
- R1: After reset both endianness bits are 0 (big-endian), the supervisor flag is clear and `out_valid` is 0.
- R2: In big-endian mode `out_addr` equals `req_addr` for every size, aligned or not, and `out_misalign` is 0.
- R3: In little-endian mode an aligned access has its three low address bits XORed with 3'b111 for a byte (`req_size`=0), 3'b110 for a halfword (1), 3'b100 for a word (2) and 3'b000 for a doubleword (3); all higher address bits are kept.
- R4: A vector access (`req_size`=4) is adjusted like a doubleword (constant 3'b000, alignment checked against 8 bytes) and enables all eight lanes.
- R5: A page-table walk access (`req_ptw`=1) is handled big-endian whatever the mode bits hold, and `out_le` is 0 for it.
- R6: In little-endian mode an access whose low address bits are not a multiple of its size sets `out_misalign` and leaves the address unmodified; in big-endian mode the flag is never set.
- R7: `out_lanes[i]` enables lane i, where lane 0 is the most significant byte (bits 63:56) of the bus; the enabled lanes run from the adjusted low three address bits upward for the operand's byte count, clipped at lane 7.
- R8: An access issued in the cycle `exc_entry` is 1 uses the supervisor bit, as do all later accesses until `exc_return`; the access issued in the cycle of `exc_return` still uses the supervisor bit and the next one uses the user bit.
- R9: A mode write (`mode_wr_en`) updates both bits for the next access issued; an access issued in the same cycle as the write uses the old bits.
- R10: With the swap stage enabled, `bus_wdata` byte k equals `core_wdata` byte 7-k and `core_rdata` byte k equals `bus_rdata` byte 7-k, with no clock in the path.
- R11: A doubleword access to the same address produces the same `out_addr` and `out_lanes` in either mode.
- R12: Results appear one clock after the request; `out_valid` is 1 exactly in the cycle after `req_valid` was 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present this cycle |
| req_addr | input | AW | Effective address of the access |
| req_size | input | 3 | 0 byte, 1 halfword, 2 word, 3 doubleword, 4 vector |
| req_ptw | input | 1 | Access belongs to a page-table walk |
| mode_wr_en | input | 1 | Write both endianness bits |
| mode_wr_user_le | input | 1 | New user endianness (1 = little) |
| mode_wr_sup_le | input | 1 | New supervisor endianness (1 = little) |
| exc_entry | input | 1 | Exception or interrupt entry this cycle |
| exc_return | input | 1 | Return from exception this cycle |
| out_valid | output | 1 | Registered result valid |
| out_addr | output | AW | Adjusted address |
| out_lanes | output | BUS_BYTES | Lane enables, bit i = lane i, lane 0 most significant |
| out_misalign | output | 1 | Unaligned access in little-endian mode |
| out_le | output | 1 | Endianness applied to this result |
| core_wdata | input | 8*BUS_BYTES | Write data from the core |
| bus_wdata | output | 8*BUS_BYTES | Write data to the bus |
| bus_rdata | input | 8*BUS_BYTES | Read data from the bus |
| core_rdata | output | 8*BUS_BYTES | Read data to the core |

## Verification
Three controls can meet an access in one cycle: an exception entry, a mode write and the access itself. The bench provokes this directly, issuing an access in the cycle that both enters the supervisor state and rewrites the supervisor bit, and expects the flip chosen by the old supervisor bit for that access and by the new bit for the one after it. Random runs also let page-table walks fall on exception entries and returns. A bench-side model of the mode state, kept only from the driven inputs, predicts every result.

// File: rtl/endian_adapt_pkg.sv
package endian_adapt_pkg;

    // Operand size codes on req_size.
    typedef enum logic [2:0] {
        SZ_BYTE  = 3'd0,
        SZ_HALF  = 3'd1,
        SZ_WORD  = 3'd2,
        SZ_DWORD = 3'd3,
        SZ_VEC   = 3'd4
    } acc_size_e;

    // Endianness state: 1 means little-endian.
    typedef struct packed {
        logic user_le;
        logic sup_le;
        logic in_sup;
    } mode_st_t;

endpackage

// File: rtl/endian_mode_reg.sv
module endian_mode_reg
    import endian_adapt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_user_le,
    input  logic wr_sup_le,
    input  logic exc_entry,
    input  logic exc_return,
    output logic active_le,
    output logic user_le,
    output logic sup_le
);

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.user_le = wr_user_le;
            st_d.sup_le  = wr_sup_le;
        end
        if (exc_entry) begin
            st_d.in_sup = 1'b1;
        end else if (exc_return) begin
            st_d.in_sup = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Entry switches the selector for the access of the entry cycle itself.
    assign active_le = (exc_entry || st_q.in_sup) ? st_q.sup_le : st_q.user_le;
    assign user_le   = st_q.user_le;
    assign sup_le    = st_q.sup_le;

endmodule

// File: rtl/endian_addr_xform.sv
module endian_addr_xform #(
    parameter  int AW        = 32,
    parameter  int BUS_BYTES = 8,
    localparam int LOW_W     = $clog2(BUS_BYTES)
) (
    input  logic [AW-1:0]    addr,
    input  logic [2:0]       size,
    input  logic             le,
    output logic [AW-1:0]    adj_addr,
    output logic             misalign,
    output logic [LOW_W:0]   nbytes
);

    localparam logic [LOW_W:0] BB = (LOW_W+1)'(BUS_BYTES);

    logic [2:0]       lg;
    logic [LOW_W-1:0] mask;
    logic [LOW_W-1:0] flip;

    always_comb begin
        // Sizes wider than the bus (vector) collapse to a full bus word.
        lg       = (int'(size) > LOW_W) ? 3'(LOW_W) : size;
        nbytes   = (LOW_W+1)'(1) << lg;
        mask     = LOW_W'(nbytes - 1'b1);
        flip     = LOW_W'(BB - nbytes);
        misalign = le && ((addr[LOW_W-1:0] & mask) != '0);
        adj_addr = addr;
        if (le && !misalign) begin
            adj_addr[LOW_W-1:0] = addr[LOW_W-1:0] ^ flip;
        end
    end

endmodule

// File: rtl/endian_lane_gen.sv
module endian_lane_gen #(
    parameter  int BUS_BYTES = 8,
    localparam int LOW_W     = $clog2(BUS_BYTES),
    localparam int SW        = LOW_W + 2
) (
    input  logic [LOW_W-1:0]     off,
    input  logic [LOW_W:0]       nbytes,
    output logic [BUS_BYTES-1:0] lanes
);

    logic [SW-1:0] lo;
    logic [SW-1:0] hi;

    assign lo = SW'(off);
    assign hi = lo + SW'(nbytes);

    for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
        assign lanes[i] = (SW'(i) >= lo) && (SW'(i) < hi);
    end

endmodule

// File: rtl/endian_byte_swap.sv
module endian_byte_swap #(
    parameter  int BUS_BYTES = 8,
    localparam int DW        = 8 * BUS_BYTES
) (
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    for (genvar i = 0; i < BUS_BYTES; i++) begin : g_byte
        assign dout[8*i +: 8] = din[8*(BUS_BYTES-1-i) +: 8];
    end

endmodule

// File: rtl/lsu_endian_adapt.sv
module lsu_endian_adapt
    import endian_adapt_pkg::*;
#(
    parameter  int AW        = 32,
    parameter  int BUS_BYTES = 8,
    parameter  int SWAP_EN   = 1,
    localparam int LOW_W     = $clog2(BUS_BYTES),
    localparam int DW        = 8 * BUS_BYTES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [AW-1:0]        req_addr,
    input  logic [2:0]           req_size,
    input  logic                 req_ptw,
    input  logic                 mode_wr_en,
    input  logic                 mode_wr_user_le,
    input  logic                 mode_wr_sup_le,
    input  logic                 exc_entry,
    input  logic                 exc_return,
    output logic                 out_valid,
    output logic [AW-1:0]        out_addr,
    output logic [BUS_BYTES-1:0] out_lanes,
    output logic                 out_misalign,
    output logic                 out_le,
    input  logic [DW-1:0]        core_wdata,
    output logic [DW-1:0]        bus_wdata,
    input  logic [DW-1:0]        bus_rdata,
    output logic [DW-1:0]        core_rdata
);

    typedef struct packed {
        logic                 valid;
        logic [AW-1:0]        addr;
        logic [BUS_BYTES-1:0] lanes;
        logic                 mis;
        logic                 le;
    } res_t;

    res_t res_d, res_q;

    logic                 active_le;
    logic                 mode_user_le;
    logic                 mode_sup_le;
    logic                 le_eff;
    logic [AW-1:0]        adj_addr;
    logic                 mis;
    logic [LOW_W:0]       nbytes;
    logic [BUS_BYTES-1:0] lanes;

    endian_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (mode_wr_en),
        .wr_user_le (mode_wr_user_le),
        .wr_sup_le  (mode_wr_sup_le),
        .exc_entry  (exc_entry),
        .exc_return (exc_return),
        .active_le  (active_le),
        .user_le    (mode_user_le),
        .sup_le     (mode_sup_le)
    );

    // Page-table walks bypass the mode bits.
    assign le_eff = req_ptw ? 1'b0 : active_le;

    endian_addr_xform #(.AW(AW), .BUS_BYTES(BUS_BYTES)) u_xform (
        .addr     (req_addr),
        .size     (req_size),
        .le       (le_eff),
        .adj_addr (adj_addr),
        .misalign (mis),
        .nbytes   (nbytes)
    );

    endian_lane_gen #(.BUS_BYTES(BUS_BYTES)) u_lanes (
        .off    (adj_addr[LOW_W-1:0]),
        .nbytes (nbytes),
        .lanes  (lanes)
    );

    always_comb begin
        res_d       = res_q;
        res_d.valid = req_valid;
        if (req_valid) begin
            res_d.addr  = adj_addr;
            res_d.lanes = lanes;
            res_d.mis   = mis;
            res_d.le    = le_eff;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid    = res_q.valid;
    assign out_addr     = res_q.addr;
    assign out_lanes    = res_q.lanes;
    assign out_misalign = res_q.mis;
    assign out_le       = res_q.le;

    if (SWAP_EN != 0) begin : g_swap
        endian_byte_swap #(.BUS_BYTES(BUS_BYTES)) u_swap_w (
            .din  (core_wdata),
            .dout (bus_wdata)
        );
        endian_byte_swap #(.BUS_BYTES(BUS_BYTES)) u_swap_r (
            .din  (bus_rdata),
            .dout (core_rdata)
        );
    end else begin : g_pass
        assign bus_wdata  = core_wdata;
        assign core_rdata = bus_rdata;
    end

endmodule

// File: rtl/endian_adapt_chk.sv
module endian_adapt_chk #(
    parameter  int AW        = 32,
    parameter  int BUS_BYTES = 8,
    parameter  int SWAP_EN   = 1,
    localparam int LOW_W     = $clog2(BUS_BYTES),
    localparam int DW        = 8 * BUS_BYTES
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [AW-1:0]        req_addr,
    input logic                 req_ptw,
    input logic                 exc_entry,
    input logic                 mode_wr_en,
    input logic                 mode_wr_user_le,
    input logic                 mode_user_le,
    input logic                 mode_sup_le,
    input logic                 out_valid,
    input logic [AW-1:0]        out_addr,
    input logic [BUS_BYTES-1:0] out_lanes,
    input logic                 out_misalign,
    input logic                 out_le,
    input logic [DW-1:0]        core_wdata,
    input logic [DW-1:0]        bus_wdata
);

    a_r12_valid_rises: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);

    a_r12_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    a_r3_high_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_addr[AW-1:LOW_W] == $past(req_addr[AW-1:LOW_W]));

    a_r2_be_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (out_le || (out_addr == $past(req_addr) && !out_misalign)));

    a_r5_walk_big_endian: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ptw) |=> (!out_le && out_addr == $past(req_addr)));

    a_r6_misalign_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!out_misalign || out_addr == $past(req_addr)));

    a_r7_lanes_present: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_lanes != '0));

    a_r8_entry_uses_sup: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && exc_entry && !req_ptw) |=> out_le == $past(mode_sup_le));

    a_r9_write_lands_next: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr_en |=> mode_user_le == $past(mode_wr_user_le));

    if (SWAP_EN != 0) begin : g_swap_chk
        a_r10_swap_ends: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wdata[7:0] == core_wdata[DW-1 -: 8]) &&
            (bus_wdata[DW-1 -: 8] == core_wdata[7:0]));
    end

endmodule

bind lsu_endian_adapt endian_adapt_chk #(
    .AW(AW), .BUS_BYTES(BUS_BYTES), .SWAP_EN(SWAP_EN)
) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_addr        (req_addr),
    .req_ptw         (req_ptw),
    .exc_entry       (exc_entry),
    .mode_wr_en      (mode_wr_en),
    .mode_wr_user_le (mode_wr_user_le),
    .mode_user_le    (mode_user_le),
    .mode_sup_le     (mode_sup_le),
    .out_valid       (out_valid),
    .out_addr        (out_addr),
    .out_lanes       (out_lanes),
    .out_misalign    (out_misalign),
    .out_le          (out_le),
    .core_wdata      (core_wdata),
    .bus_wdata       (bus_wdata)
);

// File: tb/lsu_endian_adapt_tb_top.sv
module lsu_endian_adapt_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [2:0]  req_size;
    logic        req_ptw;
    logic        mode_wr_en, mode_wr_user_le, mode_wr_sup_le;
    logic        exc_entry, exc_return;
    logic        out_valid;
    logic [31:0] out_addr;
    logic [7:0]  out_lanes;
    logic        out_misalign, out_le;
    logic [63:0] core_wdata, bus_wdata, bus_rdata, core_rdata;

    int checks = 0;
    int errors = 0;

    // Bench-side model of the mode state.
    logic m_user = 1'b0, m_sup = 1'b0, m_priv = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    lsu_endian_adapt dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_ptw(req_ptw), .mode_wr_en(mode_wr_en),
        .mode_wr_user_le(mode_wr_user_le), .mode_wr_sup_le(mode_wr_sup_le),
        .exc_entry(exc_entry), .exc_return(exc_return), .out_valid(out_valid),
        .out_addr(out_addr), .out_lanes(out_lanes), .out_misalign(out_misalign),
        .out_le(out_le), .core_wdata(core_wdata), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .core_rdata(core_rdata)
    );

    function automatic int size_bytes(input logic [2:0] sz);
        case (sz)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 4;
            default: return 8;
        endcase
    endfunction

    function automatic logic [63:0] rev64(input logic [63:0] v);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[8*k +: 8] = v[8*(7-k) +: 8];
        return r;
    endfunction

    task automatic step(input logic v, input logic [31:0] a, input logic [2:0] sz,
                        input logic ptw, input logic wr, input logic wu, input logic ws,
                        input logic ein, input logic eret, input string tag);
        logic le, mis;
        logic [31:0] ea;
        logic [7:0]  el;
        int nb;
        req_valid = v; req_addr = a; req_size = sz; req_ptw = ptw;
        mode_wr_en = wr; mode_wr_user_le = wu; mode_wr_sup_le = ws;
        exc_entry = ein; exc_return = eret;
        nb  = size_bytes(sz);
        le  = ptw ? 1'b0 : ((ein || m_priv) ? m_sup : m_user);
        mis = le && ((a % nb) != 0);
        ea  = (le && !mis) ? (a ^ 32'(8 - nb)) : a;
        for (int i = 0; i < 8; i++)
            el[i] = (i >= int'(ea[2:0])) && (i < int'(ea[2:0]) + nb);
        if (wr) begin m_user = wu; m_sup = ws; end
        if (ein) m_priv = 1'b1; else if (eret) m_priv = 1'b0;
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== v ||
            (v && (out_addr !== ea || out_lanes !== el || out_misalign !== mis || out_le !== le))) begin
            errors++;
            $display("FAIL %s: got v=%b addr=%h lanes=%b mis=%b le=%b exp v=%b addr=%h lanes=%b mis=%b le=%b",
                     tag, out_valid, out_addr, out_lanes, out_misalign, out_le,
                     v, ea, el, mis, le);
        end
        req_valid = 1'b0; mode_wr_en = 1'b0; exc_entry = 1'b0; exc_return = 1'b0;
    endtask

    task automatic acc(input logic [31:0] a, input logic [2:0] sz, input string tag);
        step(1'b1, a, sz, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic chk_data(input logic [63:0] w, input logic [63:0] r);
        core_wdata = w; bus_rdata = r;
        #1;
        checks++;
        if (bus_wdata !== rev64(w) || core_rdata !== rev64(r)) begin
            errors++;
            $display("FAIL R10: got w=%h r=%h exp w=%h r=%h",
                     bus_wdata, core_rdata, rev64(w), rev64(r));
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_ptw = 1'b0;
        mode_wr_en = 1'b0; mode_wr_user_le = 1'b0; mode_wr_sup_le = 1'b0;
        exc_entry = 1'b0; exc_return = 1'b0; core_wdata = '0; bus_rdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        checks++;
        if (out_valid !== 1'b0 || out_le !== 1'b0) begin
            errors++;
            $display("FAIL R1: got valid=%b le=%b exp valid=0 le=0", out_valid, out_le);
        end
        acc(32'h1001, 3'd0, "R1 big-endian after reset");
        // R2: big-endian pass-through
        acc(32'h2002, 3'd1, "R2 half");
        acc(32'h3004, 3'd2, "R2 word");
        acc(32'h4000, 3'd3, "R2 dword");
        acc(32'hC2,   3'd2, "R6 R2 unaligned word in big-endian");
        step(1'b0, 32'h0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R12 idle");
        // R9: write in same cycle as access uses old mode
        step(1'b1, 32'h10, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9 same-cycle write");
        acc(32'h10, 3'd0, "R9 R3 byte after write");
        acc(32'h22, 3'd1, "R3 half");
        acc(32'h34, 3'd2, "R3 word");
        acc(32'h48, 3'd3, "R3 R11 dword");
        acc(32'h58, 3'd4, "R4 vector");
        acc(32'h5C, 3'd4, "R4 vector misaligned");
        step(1'b1, 32'h61, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 walk byte");
        step(1'b1, 32'h66, 3'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 walk unaligned");
        acc(32'h71, 3'd1, "R6 misaligned half");
        acc(32'h7D, 3'd0, "R7 byte lane");
        acc(32'h06, 3'd1, "R7 half lanes");
        // R8: exception entry and return
        step(1'b1, 32'h90, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R8 entry cycle");
        acc(32'h91, 3'd0, "R8 in supervisor");
        step(1'b1, 32'hA0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R8 return cycle");
        acc(32'hA0, 3'd0, "R8 back to user");
        // entry plus supervisor-bit write plus access, all in one cycle
        step(1'b1, 32'hB1, 3'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R8 R9 entry with write");
        acc(32'hB1, 3'd0, "R8 R9 supervisor after write");
        step(1'b1, 32'hB2, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R8 return");
        // R11: doubleword round trip across a mode switch
        step(1'b1, 32'hB8, 3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R11 store in old mode");
        acc(32'hB8, 3'd3, "R11 store big-endian");
        step(1'b1, 32'hB8, 3'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R11 before switch");
        acc(32'hB8, 3'd3, "R11 load little-endian");
        // R10: data swap stage
        chk_data(64'h0102_0304_0506_0708, 64'h1122_3344_5566_7788);
        chk_data(64'hFF00_0000_0000_00AA, 64'h0000_00C3_5A00_0000);

        // Random mix
        for (int n = 0; n < 600; n++) begin
            logic v, ptw, wr, ein, eret;
            v    = ($urandom % 5) != 0;
            ptw  = ($urandom % 8) == 0;
            wr   = ($urandom % 12) == 0;
            ein  = !m_priv && (($urandom % 10) == 0);
            eret = m_priv && (($urandom % 6) == 0);
            step(v, $urandom & 32'h0000_FFFF, 3'($urandom_range(0, 4)), ptw, wr,
                 1'($urandom), 1'($urandom), ein, eret, "R3 R6 R7 R8 random");
            if ((n % 50) == 0) chk_data({$urandom, $urandom}, {$urandom, $urandom});
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule